// File: doc/BRIEF.md
# Infrared Front-End Receive-Mode Sequencer

This block sits on the host side of a serial infrared front end and owns the two control lines that run into it: the shutdown line and the transmit-data line. It accepts one command at a time over a valid/ready handshake: select the short receive pulse, select the long receive pulse, put the front end to sleep, or wake it. For a mode change it raises the shutdown line, drives the transmit line to the level that encodes the mode, holds that level across the falling edge of the shutdown line, and then hands the transmit line back to the host.

Sleep holds the shutdown line high for at least the power-down time. Wake drops it and waits out the receiver recovery time. Waking also returns the front end to its short-pulse default. Each command ends with a one-cycle `done` pulse. While the block is awake and idle, host transmit data passes straight through to the transmit line. While a sequence runs, host transmit data is blocked. All phase lengths are parameters counted in clock cycles.

Top module: `ir_mode_sequencer`

## Requirements
- R1: After reset, `sd_out` is low, `cmd_ready` is high, `done` is low, and `txd_out` follows `tx_data_in`.
- R2: While awake and idle, `txd_out` equals `tx_data_in` in the same cycle, and `sd_out` stays low.
- R3: A mode command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. Mode commands are `cmd_op` 0 (short) and 1 (long). After acceptance, `sd_out` is high for 1+SETUP_CYC cycles. `txd_out` is low in the first of these cycles and at the mode level in the remaining SETUP_CYC cycles.
- R4: The mode level is 1 for the short command and 0 for the long command. The level present when `sd_out` falls is that level.
- R5: After `sd_out` falls, `txd_out` keeps the mode level for HOLD_CYC cycles. In the following cycle `done` is high for one cycle and passthrough resumes.
- R6: `cmd_ready` is low from acceptance until the cycle of `done`. Commands presented during that time have no effect on the lines.
- R7: A sleep command (`cmd_op` 2) from the awake state holds `sd_out` high and `txd_out` low for SHDN_CYC cycles. Then `done` pulses, and `sd_out` stays high afterwards.
- R8: While asleep, `txd_out` stays low whatever `tx_data_in` does. Short, long and sleep commands are accepted and answered with `done` in the next cycle, and the lines do not change.
- R9: A wake command (`cmd_op` 3) from the asleep state drives `sd_out` low and `txd_out` low for RECOV_CYC cycles. Then `done` pulses and passthrough resumes.
- R10: A wake command while awake is answered with `done` in the next cycle and starts no sequence.
- R11: A mode sequence lasts at most PROG_LIMIT_CYC cycles. A driven high level on `txd_out` lasts fewer than TXD_LIMIT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 0 short, 1 long, 2 sleep, 3 wake |
| cmd_ready | output | 1 | Block can accept a command |
| tx_data_in | input | 1 | Host transmit data for passthrough |
| sd_out | output | 1 | Shutdown / programming line to the front end |
| txd_out | output | 1 | Transmit line to the front end |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach from the ports is a command that arrives while a sequence is under way, together with transmit data that toggles during the same sequence. A busy-time command must leave the waveform untouched, and toggling data must not leak onto the line. The stimulus therefore drives random junk commands and random transmit data on every cycle of every sequence. It drops the junk only in the cycle where `done` is due. Random command order also reaches the no-op paths: mode and sleep requests while asleep, and wake while awake.

// File: rtl/ir_seq_pkg.sv
package ir_seq_pkg;

    typedef enum logic [1:0] {
        OP_SHORT = 2'd0,
        OP_LONG  = 2'd1,
        OP_SLEEP = 2'd2,
        OP_WAKE  = 2'd3
    } ir_op_e;

    typedef enum logic [2:0] {
        ST_AWAKE,
        ST_RAISE,
        ST_SETUP,
        ST_HOLD,
        ST_SLEEP_IN,
        ST_ASLEEP,
        ST_WAKE
    } ir_state_e;

endpackage

// File: rtl/ir_seq_timer.sv
module ir_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ir_seq_fsm.sv
module ir_seq_fsm
    import ir_seq_pkg::*;
#(
    parameter int SETUP_CYC      = 32,
    parameter int HOLD_CYC       = 32,
    parameter int SHDN_CYC       = 200000,
    parameter int RECOV_CYC      = 40000,
    parameter int PROG_LIMIT_CYC = 75000,
    parameter int TXD_LIMIT_CYC  = 10000,
    parameter int CNT_W          = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cmd_ready,
    output logic             pass_en,
    output logic             sd_drv,
    output logic             txd_drv,
    output logic             done
);
    typedef struct packed {
        ir_state_e st;
        logic      sd;
        logic      txd;
        logic      lvl;
        logic      done;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (s_q.st)
            ST_AWAKE: if (cmd_valid) begin
                unique case (ir_op_e'(cmd_op))
                    OP_SHORT, OP_LONG: begin
                        s_d.st   = ST_RAISE;
                        s_d.sd   = 1'b1;
                        s_d.txd  = 1'b0;
                        s_d.lvl  = (ir_op_e'(cmd_op) == OP_SHORT);
                        tmr_load = 1'b1;
                    end
                    OP_SLEEP: begin
                        s_d.st   = ST_SLEEP_IN;
                        s_d.sd   = 1'b1;
                        s_d.txd  = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(SHDN_CYC - 1);
                    end
                    default: s_d.done = 1'b1;
                endcase
            end
            ST_RAISE: if (tmr_zero) begin
                s_d.st   = ST_SETUP;
                s_d.txd  = s_q.lvl;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETUP_CYC - 1);
            end
            ST_SETUP: if (tmr_zero) begin
                s_d.st   = ST_HOLD;
                s_d.sd   = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_zero) begin
                s_d.st   = ST_AWAKE;
                s_d.txd  = 1'b0;
                s_d.done = 1'b1;
            end
            ST_SLEEP_IN: if (tmr_zero) begin
                s_d.st   = ST_ASLEEP;
                s_d.done = 1'b1;
            end
            ST_ASLEEP: if (cmd_valid) begin
                if (ir_op_e'(cmd_op) == OP_WAKE) begin
                    s_d.st   = ST_WAKE;
                    s_d.sd   = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(RECOV_CYC - 1);
                end else begin
                    s_d.done = 1'b1;
                end
            end
            ST_WAKE: if (tmr_zero) begin
                s_d.st   = ST_AWAKE;
                s_d.done = 1'b1;
            end
            default: s_d.st = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_AWAKE, sd: 1'b0, txd: 1'b0, lvl: 1'b1, done: 1'b0};
        else        s_q <= s_d;
    end

    assign cmd_ready = (s_q.st == ST_AWAKE) || (s_q.st == ST_ASLEEP);
    assign pass_en   = (s_q.st == ST_AWAKE);
    assign sd_drv    = s_q.sd;
    assign txd_drv   = s_q.txd;
    assign done      = s_q.done;

    // Duration watch counters for the limit checks
    logic        in_prog;
    logic [31:0] prog_cnt_q, hi_cnt_q;
    assign in_prog = (s_q.st == ST_RAISE) || (s_q.st == ST_SETUP) || (s_q.st == ST_HOLD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_cnt_q <= '0;
            hi_cnt_q   <= '0;
        end else begin
            prog_cnt_q <= in_prog ? prog_cnt_q + 1 : '0;
            hi_cnt_q   <= (!pass_en && s_q.txd) ? hi_cnt_q + 1 : '0;
        end
    end

    p_prog_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_cnt_q <= 32'(PROG_LIMIT_CYC));
    p_txd_high_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt_q < 32'(TXD_LIMIT_CYC));
    p_fall_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.sd) && s_q.st == ST_HOLD) |-> (s_q.txd == s_q.lvl));
    p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && s_q.st == ST_AWAKE && cmd_op <= 2'd2) |=> !cmd_ready);
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_asleep_sd_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_ASLEEP) |-> (s_q.sd && !s_q.txd));
endmodule

// File: rtl/ir_seq_txd_mux.sv
module ir_seq_txd_mux (
    input  logic pass_en,
    input  logic tx_data_in,
    input  logic txd_drv,
    output logic txd_out
);
    assign txd_out = pass_en ? tx_data_in : txd_drv;
endmodule

// File: rtl/ir_mode_sequencer.sv
module ir_mode_sequencer #(
    parameter int SETUP_CYC      = 32,
    parameter int HOLD_CYC       = 32,
    parameter int SHDN_CYC       = 200000,
    parameter int RECOV_CYC      = 40000,
    parameter int PROG_LIMIT_CYC = 75000,
    parameter int TXD_LIMIT_CYC  = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cmd_ready,
    input  logic       tx_data_in,
    output logic       sd_out,
    output logic       txd_out,
    output logic       done
);
    localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_B   = (SHDN_CYC > RECOV_CYC) ? SHDN_CYC : RECOV_CYC;
    localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_zero, pass_en, sd_drv, txd_drv;
    logic [CNT_W-1:0] tmr_val;

    ir_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    ir_seq_fsm #(
        .SETUP_CYC      (SETUP_CYC),
        .HOLD_CYC       (HOLD_CYC),
        .SHDN_CYC       (SHDN_CYC),
        .RECOV_CYC      (RECOV_CYC),
        .PROG_LIMIT_CYC (PROG_LIMIT_CYC),
        .TXD_LIMIT_CYC  (TXD_LIMIT_CYC),
        .CNT_W          (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cmd_ready (cmd_ready),
        .pass_en   (pass_en),
        .sd_drv    (sd_drv),
        .txd_drv   (txd_drv),
        .done      (done)
    );

    ir_seq_txd_mux i_mux (
        .pass_en    (pass_en),
        .tx_data_in (tx_data_in),
        .txd_drv    (txd_drv),
        .txd_out    (txd_out)
    );

    assign sd_out = sd_drv;

    p_ready_returns_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> done);
    p_idle_sd_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_en && !done) |-> !sd_out);
endmodule

// File: tb/test_ir_mode_sequencer.sv
module test_ir_mode_sequencer;
    localparam int SETUP = 6, HOLD = 5, SHDN = 24, RECOV = 14;
    localparam int PLIM = 20, TLIM = 15;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, tx_data_in = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_ready, sd_out, txd_out, done;
    int checks = 0, errors = 0;
    bit shut = 1'b0;

    always #4 clk = ~clk;

    ir_mode_sequencer #(
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .SHDN_CYC(SHDN),
        .RECOV_CYC(RECOV), .PROG_LIMIT_CYC(PLIM), .TXD_LIMIT_CYC(TLIM)
    ) i_ir_mode_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .tx_data_in(tx_data_in), .sd_out(sd_out),
        .txd_out(txd_out), .done(done)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int seq_len(int op, bit sh);
        if (!sh && op <= 1) return 1 + SETUP + HOLD;
        if (!sh && op == 2) return SHDN;
        if (sh && op == 3)  return RECOV;
        return 0;
    endfunction

    // returns {ready, done, sd, txd}
    function automatic logic [3:0] exp_out(int op, bit sh, int j, int len, bit tx);
        bit sh_n, lvl;
        sh_n = (!sh && op == 2) ? 1'b1 : (sh && op == 3) ? 1'b0 : sh;
        lvl  = (op == 0);
        if (j == len) return {2'b11, sh_n, sh_n ? 1'b0 : tx};
        if (!sh && op <= 1) begin
            if (j == 0)      return 4'b0010;
            if (j <= SETUP)  return {3'b001, lvl};
            return {3'b000, lvl};
        end
        if (!sh && op == 2) return 4'b0010;
        return 4'b0000;
    endfunction

    function automatic string tag(int op, bit sh, int j);
        if (!sh && op <= 1) return (j <= SETUP) ? "R3" : (j == SETUP + 1) ? "R4" : "R5";
        if (!sh && op == 2) return "R7";
        if (sh && op == 3)  return "R9";
        return sh ? "R8" : "R10";
    endfunction

    task automatic run_cmd(int op);
        int len, hi_run, hi_max;
        logic [3:0] e;
        string t;
        len = seq_len(op, shut);
        hi_run = 0; hi_max = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); tx_data_in = 1'($urandom);
        @(posedge clk);
        for (int j = 0; j <= len; j++) begin
            @(negedge clk);
            e = exp_out(op, shut, j, len, tx_data_in);
            t = tag(op, shut, j);
            if (j < len) check("R6", "ready busy", int'(cmd_ready), 0);
            check(t, "done", int'(done), int'(e[2]));
            check(t, "sd", int'(sd_out), int'(e[1]));
            check(t, "txd", int'(txd_out), int'(e[0]));
            if (j == len) check(t, "ready end", int'(cmd_ready), 1);
            if (j < len && txd_out) hi_run++; else hi_run = 0;
            if (hi_run > hi_max) hi_max = hi_run;
            tx_data_in = 1'($urandom);
            if (j + 1 < len) begin
                cmd_valid = 1'($urandom);   // R6: ignored while busy
                cmd_op    = 2'($urandom);
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        if (!shut && op <= 1) begin
            check("R11", "prog length within limit", int'(len <= PLIM), 1);
            check("R11", "txd high run within limit", int'(hi_max < TLIM), 1);
        end
        if (!shut && op == 2) shut = 1'b1;
        else if (shut && op == 3) shut = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tx_data_in = 1'($urandom);
            #1;
            check(shut ? "R8" : "R2", "idle txd", int'(txd_out), shut ? 0 : int'(tx_data_in));
            check(shut ? "R8" : "R2", "idle sd", int'(sd_out), int'(shut));
            check(shut ? "R8" : "R2", "idle done", int'(done), 0);
            check(shut ? "R8" : "R2", "idle ready", int'(cmd_ready), 1);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #20;
        tx_data_in = 1'b1; #1;
        check("R1", "reset sd", int'(sd_out), 0);
        check("R1", "reset ready", int'(cmd_ready), 1);
        check("R1", "reset done", int'(done), 0);
        check("R1", "reset txd pass", int'(txd_out), 1);
        @(negedge clk); rst_n = 1'b1;
        idle_cycles(3);
        run_cmd(1); idle_cycles(2);   // long mode
        run_cmd(0); idle_cycles(2);   // short mode
        run_cmd(3); idle_cycles(1);   // R10 wake while awake
        run_cmd(2); idle_cycles(3);   // R7 sleep
        run_cmd(0); run_cmd(2); idle_cycles(2);  // R8 no-ops asleep
        run_cmd(3); idle_cycles(2);   // R9 wake
        for (int n = 0; n < 50; n++) begin
            run_cmd(int'($urandom_range(3, 0)));
            idle_cycles(int'($urandom_range(3, 0)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule